// File: doc/BRIEF.md
# Addressed Three-Wire Serial Control Slave

This block is the target side of a three-wire serial bus made of a chip-enable line, a serial clock and a data-in line, plus a separate open-drain data-out line. While chip-enable is low, the controller clocks in an 8-bit address. When chip-enable rises, the data phase begins, and the address selects what it does: a write of one of two 32-bit control words, or a status read.

A written word is collected in a shadow shift register. It is copied into its holding register, with a one-cycle strobe, only when chip-enable falls. A read takes a snapshot of seven input-port bits and a 20-bit counter value when the data phase starts, and shifts them out most significant bit first. At all other times the data-out line acts as a live status line. It is pulled low by a selected condition: unlock, count complete, or a latched change on a watched input.

All bus pins are asynchronous to the system clock. They pass through synchronisers and are sampled on detected serial-clock edges. Decoding of the fields inside the control words is left to the logic that consumes them.

Top module: `scs_top`

## Requirements
- R1: After reset, do_o is high (released), word1_o and word2_o are zero, and neither strobe is asserted.
- R2: The first address bit sent lands in address bit 7. Address 0x12 selects control word 1, 0x92 selects control word 2 and 0x52 selects the read mode. At most one write strobe is asserted in any cycle.
- R3: A write data phase carries 32 bits, and the first data bit sent becomes bit 0 of the word.
- R4: A holding register and its strobe change only after chip-enable falls. During the data phase the old word stays visible, and each committed write gives exactly one strobe pulse.
- R5: A write frame with fewer than 32 data bits commits nothing.
- R6: Data bits sent after the 32nd in a write frame are ignored.
- R7: A frame with an unrecognised address changes neither word, produces no strobe, and leaves do_o carrying the status line.
- R8: A read outputs port_i[6] down to port_i[0], then count_i[19] down to count_i[0], all captured at the start of the data phase. The first bit is valid before the first rising serial clock, and each later bit follows a falling serial clock.
- R9: After the 27th falling serial clock of a read, do_o is released (high) until chip-enable falls.
- R10: Outside a read, stat_sel_i = 00 keeps do_o released. stat_sel_i = 01 pulls do_o low while unlock_i is high, and stat_sel_i = 10 pulls it low while count_done_i is high.
- R11: With stat_sel_i = 11, any change on chg_i latches a pull-low on do_o. The latch holds until the next chip-enable rise clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Chip-enable (low: address, high: data phase) |
| cl_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Open-drain data out, 1 = released |
| port_i | input | 7 | Input-port bits for read (bit 6 sent first) |
| count_i | input | 20 | Counter value for read |
| unlock_i | input | 1 | Unlock condition, active high |
| count_done_i | input | 1 | Count complete, active high |
| chg_i | input | 1 | Watched input for change detection |
| stat_sel_i | input | 2 | Status source on do_o outside reads |
| word1_o | output | 32 | Control word 1 holding register |
| word2_o | output | 32 | Control word 2 holding register |
| word1_stb_o | output | 1 | One-cycle pulse when word 1 commits |
| word2_stb_o | output | 1 | One-cycle pulse when word 2 commits |

## Verification
The hardest situation to reach is a frame that has been fully shifted but not yet committed. The same applies to its neighbours: frames cut short or run past 32 bits, and a read whose output must be released after exactly 27 falling clocks. The bench drives whole bus frames bit by bit from a task. That task can leave chip-enable high after the last bit, so the old word can be checked before the commit. It also takes an arbitrary bit count, which yields the short and over-long frames. The status line is exercised during an unrecognised frame by holding unlock high and sampling do_o at every clock of the ignored data phase.

// File: rtl/scs_pkg.sv
package scs_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] ADDR_WR1 = 8'h12;
  localparam logic [ADDR_W-1:0] ADDR_WR2 = 8'h92;
  localparam logic [ADDR_W-1:0] ADDR_RD  = 8'h52;

  typedef enum logic [1:0] {M_IDLE, M_WR1, M_WR2, M_RD} mode_e;
  typedef enum logic [1:0] {ST_OFF, ST_UNLOCK, ST_DONE, ST_CHG} stat_e;

  function automatic mode_e decode(input logic [ADDR_W-1:0] a);
    case (a)
      ADDR_WR1: decode = M_WR1;
      ADDR_WR2: decode = M_WR2;
      ADDR_RD:  decode = M_RD;
      default:  decode = M_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/scs_sync.sv
module scs_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) q[s] <= '0;
    end else begin
      q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) q[s] <= q[s-1];
    end
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/scs_rx.sv
module scs_rx
  import scs_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              ce_rise_i,
  input  logic              ce_fall_i,
  input  logic              cl_rise_i,
  input  logic              di_i,
  output mode_e             mode_o,
  output logic              rd_load_o,
  output logic [WORD_W-1:0] word1_o,
  output logic [WORD_W-1:0] word2_o,
  output logic              word1_stb_o,
  output logic              word2_stb_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  mode_e             mode_q;
  logic              wr_mode;

  assign wr_mode = (mode_q == M_WR1) || (mode_q == M_WR2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q      <= '0;
      sh_q        <= '0;
      cnt_q       <= '0;
      mode_q      <= M_IDLE;
      rd_load_o   <= 1'b0;
      word1_o     <= '0;
      word2_o     <= '0;
      word1_stb_o <= 1'b0;
      word2_stb_o <= 1'b0;
    end else begin
      word1_stb_o <= 1'b0;
      word2_stb_o <= 1'b0;
      rd_load_o   <= 1'b0;
      if (ce_fall_i) begin
        // commit only complete words
        if (mode_q == M_WR1 && cnt_q == FULL) begin
          word1_o     <= sh_q;
          word1_stb_o <= 1'b1;
        end
        if (mode_q == M_WR2 && cnt_q == FULL) begin
          word2_o     <= sh_q;
          word2_stb_o <= 1'b1;
        end
        mode_q <= M_IDLE;
        addr_q <= '0;
      end else if (ce_rise_i) begin
        mode_q    <= decode(addr_q);
        rd_load_o <= (decode(addr_q) == M_RD);
        cnt_q     <= '0;
      end else if (cl_rise_i) begin
        if (!ce_i) begin
          addr_q <= {addr_q[ADDR_W-2:0], di_i};
        end else if (wr_mode && cnt_q != FULL) begin
          sh_q  <= {di_i, sh_q[WORD_W-1:1]};
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/scs_tx.sv
module scs_tx
  import scs_pkg::*;
#(
  parameter int TOT = 27
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           rd_active_i,
  input  logic           rd_load_i,
  input  logic           cl_fall_i,
  input  logic [TOT-1:0] snap_i,
  input  logic [1:0]     stat_sel_i,
  input  logic           unlock_i,
  input  logic           done_i,
  input  logic           chg_flag_i,
  output logic           busy_o,
  output logic           do_o
);
  localparam int LEFT_W = $clog2(TOT + 1);

  logic [TOT-1:0]    sh_q;
  logic [LEFT_W-1:0] left_q;
  logic              pull;

  always_comb begin
    case (stat_e'(stat_sel_i))
      ST_UNLOCK: pull = unlock_i;
      ST_DONE:   pull = done_i;
      ST_CHG:    pull = chg_flag_i;
      default:   pull = 1'b0;
    endcase
  end

  assign busy_o = (left_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
      do_o   <= 1'b1;
    end else begin
      if (rd_load_i) begin
        sh_q   <= snap_i;
        left_q <= LEFT_W'(TOT);
      end else if (!rd_active_i) begin
        left_q <= '0;
      end else if (cl_fall_i && busy_o) begin
        sh_q   <= {sh_q[TOT-2:0], 1'b0};
        left_q <= left_q - 1'b1;
      end
      do_o <= rd_active_i ? (busy_o ? sh_q[TOT-1] : 1'b1) : !pull;
    end
  end
endmodule

// File: rtl/scs_top.sv
module scs_top
  import scs_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int PORT_W = 7,
  parameter int CNT_W  = 20,
  parameter int SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              cl_i,
  input  logic              di_i,
  output logic              do_o,
  input  logic [PORT_W-1:0] port_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              unlock_i,
  input  logic              count_done_i,
  input  logic              chg_i,
  input  logic [1:0]        stat_sel_i,
  output logic [WORD_W-1:0] word1_o,
  output logic [WORD_W-1:0] word2_o,
  output logic              word1_stb_o,
  output logic              word2_stb_o
);
  localparam int TOT = PORT_W + CNT_W;

  logic [3:0] pins_s;
  logic       ce_s, cl_s, di_s, chg_s;
  logic       ce_d, cl_d, chg_d;
  logic       ce_rise, ce_fall, cl_rise, cl_fall;
  logic       chg_flag;
  logic       rd_load, rd_active, tx_busy;
  mode_e      mode;

  scs_sync #(.W(4), .STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({chg_i, di_i, cl_i, ce_i}),
    .q_o   (pins_s)
  );

  assign {chg_s, di_s, cl_s, ce_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_d     <= 1'b0;
      cl_d     <= 1'b0;
      chg_d    <= 1'b0;
      chg_flag <= 1'b0;
    end else begin
      ce_d  <= ce_s;
      cl_d  <= cl_s;
      chg_d <= chg_s;
      if (chg_s ^ chg_d)  chg_flag <= 1'b1;
      else if (ce_rise)   chg_flag <= 1'b0;
    end
  end

  assign ce_rise   = ce_s & ~ce_d;
  assign ce_fall   = ~ce_s & ce_d;
  assign cl_rise   = cl_s & ~cl_d;
  assign cl_fall   = ~cl_s & cl_d;
  assign rd_active = (mode == M_RD);

  scs_rx #(.WORD_W(WORD_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ce_i       (ce_s),
    .ce_rise_i  (ce_rise),
    .ce_fall_i  (ce_fall),
    .cl_rise_i  (cl_rise),
    .di_i       (di_s),
    .mode_o     (mode),
    .rd_load_o  (rd_load),
    .word1_o    (word1_o),
    .word2_o    (word2_o),
    .word1_stb_o(word1_stb_o),
    .word2_stb_o(word2_stb_o)
  );

  scs_tx #(.TOT(TOT)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_active_i(rd_active),
    .rd_load_i  (rd_load),
    .cl_fall_i  (cl_fall),
    .snap_i     ({port_i, count_i}),
    .stat_sel_i (stat_sel_i),
    .unlock_i   (unlock_i),
    .done_i     (count_done_i),
    .chg_flag_i (chg_flag),
    .busy_o     (tx_busy),
    .do_o       (do_o)
  );
endmodule

// File: rtl/scs_chk.sv
module scs_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_fall,
  input logic              rd_active,
  input logic              tx_busy,
  input logic [1:0]        stat_sel_i,
  input logic              unlock_i,
  input logic              do_o,
  input logic [WORD_W-1:0] word1_o,
  input logic [WORD_W-1:0] word2_o,
  input logic              word1_stb_o,
  input logic              word2_stb_o
);
  p_stb_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(word1_stb_o && word2_stb_o));

  p_stb1_after_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word1_stb_o |-> $past(ce_fall));

  p_stb2_after_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word2_stb_o |-> $past(ce_fall));

  p_word1_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word1_stb_o |-> $stable(word1_o));

  p_word2_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word2_stb_o |-> $stable(word2_o));

  p_release_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_active && !tx_busy) |=> do_o);

  p_stat_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_active && stat_sel_i == 2'b00) |=> do_o);

  p_stat_unlock_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_active && stat_sel_i == 2'b01 && unlock_i) |=> !do_o);
endmodule

bind scs_top scs_chk #(.WORD_W(32)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ce_fall    (ce_fall),
  .rd_active  (rd_active),
  .tx_busy    (tx_busy),
  .stat_sel_i (stat_sel_i),
  .unlock_i   (unlock_i),
  .do_o       (do_o),
  .word1_o    (word1_o),
  .word2_o    (word2_o),
  .word1_stb_o(word1_stb_o),
  .word2_stb_o(word2_stb_o)
);

// File: tb/sim_scs_top.sv
`timescale 1ns/1ps
module sim_scs_top;
  localparam time T = 60ns;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ce = 1'b0, cl = 1'b0, di = 1'b0;
  logic [6:0]  port = '0;
  logic [19:0] count = '0;
  logic        unlock = 1'b0, done = 1'b0, chg = 1'b0;
  logic [1:0]  sel = 2'b00;
  logic        do_w, s1, s2;
  logic [31:0] w1, w2;

  int n_tests = 0, n_fail = 0, n_s1 = 0, n_s2 = 0;

  always #2.5ns clk = ~clk;

  scs_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .cl_i(cl), .di_i(di), .do_o(do_w),
    .port_i(port), .count_i(count), .unlock_i(unlock), .count_done_i(done),
    .chg_i(chg), .stat_sel_i(sel), .word1_o(w1), .word2_o(w2),
    .word1_stb_o(s1), .word2_stb_o(s2)
  );

  always @(posedge clk) begin
    if (s1) n_s1++;
    if (s2) n_s2++;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [26:0] exp_read(input logic [6:0] p, input logic [19:0] c);
    return {p, c};
  endfunction

  // one bus frame; rd collects do_o before each rising clock, rel is do_o after the last bit
  task automatic xfer(input logic [7:0] addr, input int nbits, input logic [31:0] data,
                      input bit drop, output logic [26:0] rd, output logic rel);
    rd = '1;
    for (int i = 0; i < 8; i++) begin
      di = addr[7-i]; #T cl = 1'b1; #T cl = 1'b0;
    end
    #T ce = 1'b1; #T;
    for (int i = 0; i < nbits; i++) begin
      if (i < 27) rd[26-i] = do_w;
      di = (i < 32) ? data[i] : 1'($urandom);
      #T cl = 1'b1; #T cl = 1'b0; #T;
    end
    rel = do_w;
    if (drop) begin
      ce = 1'b0; #(2*T);
    end
  endtask

  task automatic finish_up;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #750us;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [26:0] rd;
    logic        rel;
    logic [31:0] d, e1, e2;
    int          b1, b2;
    void'($urandom(32'h5EED_1234));
    #23ns rst_n = 1'b1;
    #50ns;
    // R1
    chk("R1 do", do_w, 1'b1);
    chk("R1 word1", w1, 32'h0);
    chk("R1 word2", w2, 32'h0);
    chk("R1 strobes", n_s1 + n_s2, 0);

    // R2 R3 directed
    xfer(8'h12, 32, 32'h0000_0001, 1'b1, rd, rel);
    chk("R3 lsb first", w1, 32'h0000_0001);
    xfer(8'h92, 32, 32'h8000_0000, 1'b1, rd, rel);
    chk("R2 word2 addr", w2, 32'h8000_0000);
    chk("R2 word1 untouched", w1, 32'h0000_0001);
    e1 = 32'h1; e2 = 32'h8000_0000;

    // R2 R3 random writes
    for (int k = 0; k < 14; k++) begin
      bit which = 1'($urandom);
      d = $urandom;
      b1 = n_s1; b2 = n_s2;
      xfer(which ? 8'h92 : 8'h12, 32, d, 1'b1, rd, rel);
      if (which) e2 = d; else e1 = d;
      chk("R3 word1", w1, e1);
      chk("R3 word2", w2, e2);
      chk("R2 strobe", {n_s1 - b1, n_s2 - b2}, which ? {32'd0, 32'd1} : {32'd1, 32'd0});
    end

    // R4 commit at ce fall only
    d = 32'hA5C3_0F96; b1 = n_s1;
    xfer(8'h12, 32, d, 1'b0, rd, rel);
    chk("R4 old word during data phase", w1, e1);
    chk("R4 no strobe before fall", n_s1 - b1, 0);
    ce = 1'b0; #(2*T);
    e1 = d;
    chk("R4 word after fall", w1, e1);
    chk("R4 single strobe", n_s1 - b1, 1);

    // R5 short frame
    b2 = n_s2;
    xfer(8'h92, 31, 32'h1234_5678, 1'b1, rd, rel);
    chk("R5 short frame", w2, e2);
    chk("R5 no strobe", n_s2 - b2, 0);

    // R6 extra bits
    d = 32'h0BAD_F00D;
    xfer(8'h92, 40, d, 1'b1, rd, rel);
    e2 = d;
    chk("R6 extra bits ignored", w2, e2);

    // R7 unknown address, unlock shown throughout
    sel = 2'b01; unlock = 1'b1; b1 = n_s1; b2 = n_s2;
    xfer(8'h13, 32, 32'hFFFF_FFFF, 1'b1, rd, rel);
    chk("R7 status during ignored frame", rd, 27'h0);
    chk("R7 words", {w1, w2}, {e1, e2});
    chk("R7 strobes", (n_s1 - b1) + (n_s2 - b2), 0);
    unlock = 1'b0; sel = 2'b00;

    // R8 R9 reads
    for (int k = 0; k < 4; k++) begin
      logic [6:0]  p = 7'($urandom);
      logic [19:0] c = 20'($urandom);
      if (k == 0) begin p = 7'h7F; c = 20'h0_0000; end
      if (k == 1) begin p = 7'h00; c = 20'hF_FFFF; end
      port = p; count = c;
      sel = 2'b01; unlock = 1'b1; // status must not leak into a read
      xfer(8'h52, 28, 32'h0, 1'b1, rd, rel);
      chk("R8 read bits", rd, exp_read(p, c));
      chk("R9 released after last bit", rel, 1'b1);
      unlock = 1'b0; sel = 2'b00;
    end

    // R10 status select
    sel = 2'b01; unlock = 1'b1; #100ns;
    chk("R10 unlock low", do_w, 1'b0);
    unlock = 1'b0; #100ns;
    chk("R10 unlock cleared", do_w, 1'b1);
    sel = 2'b10; done = 1'b1; #100ns;
    chk("R10 done low", do_w, 1'b0);
    sel = 2'b00; unlock = 1'b1; #100ns;
    chk("R10 off released", do_w, 1'b1);
    unlock = 1'b0; done = 1'b0;

    // R11 sticky change flag
    sel = 2'b11; #100ns;
    chk("R11 idle released", do_w, 1'b1);
    chg = 1'b1; #100ns;
    chk("R11 change latched", do_w, 1'b0);
    chg = 1'b0; #100ns;
    chk("R11 still latched", do_w, 1'b0);
    xfer(8'h12, 32, e1, 1'b1, rd, rel);
    chk("R11 cleared by frame", do_w, 1'b1);
    sel = 2'b00;

    finish_up();
  end
endmodule